// File: doc/BRIEF.md
# Codeword Bit-Flip Injector

This block sits on the path between an error-correcting encoder and its decoder. It takes a 39-bit codeword, with the 7 check bits in the top bits and the 32 data bits below them. It inverts one or two chosen bit positions and passes the damaged word on. The number of flips follows the same mode signal that sets the decoder's mode. A low mode selects single-error correction, so one bit is flipped. A high mode selects double-error detection, so two distinct bits are flipped.

The block has no clock or state. Two 6-bit position indices choose the bits. The bench or a formal environment can drive any index value, and the block guards itself against bad ones. A position outside the codeword, or two equal positions in dual mode, raises an invalid-request flag. In that case the word passes through untouched. Whenever the flag is low, the output is guaranteed to differ from the input.

Top module: `cw_err_inject`

## Requirements
- R1: With mode_i=0 and pos_a_i in 0..38, cw_o equals cw_i with only bit pos_a_i inverted, and bad_req_o=0.
- R2: With mode_i=1, pos_a_i and pos_b_i both in 0..38 and unequal, cw_o equals cw_i with exactly bits pos_a_i and pos_b_i inverted, and bad_req_o=0.
- R3: With mode_i=0, the value of pos_b_i has no effect on cw_o or bad_req_o, even when it is out of range or equal to pos_a_i.
- R4: pos_a_i in 39..63 sets bad_req_o=1 and cw_o=cw_i, in either mode.
- R5: With mode_i=1, pos_b_i in 39..63 sets bad_req_o=1 and cw_o=cw_i.
- R6: With mode_i=1 and pos_a_i equal to pos_b_i, bad_req_o=1 and cw_o=cw_i.
- R7: Whenever bad_req_o=0, cw_o differs from cw_i in exactly 1 bit when mode_i=0 and in exactly 2 bits when mode_i=1.
- R8: data_o equals cw_o[31:0] and chk_o equals cw_o[38:32].
- R9: The outputs are a pure function of the current inputs and settle within the same cycle, without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cw_i | input | 39 | Codeword from the encoder: check bits in [38:32], data bits in [31:0] |
| pos_a_i | input | 6 | First flip position, valid values 0..38 |
| pos_b_i | input | 6 | Second flip position, used only in dual mode |
| mode_i | input | 1 | 0 = one flip, 1 = two flips |
| cw_o | output | 39 | Corrupted codeword |
| data_o | output | 32 | Data field of cw_o |
| chk_o | output | 7 | Check field of cw_o |
| bad_req_o | output | 1 | Invalid position request; the word passes through unflipped |

## Verification
The bench sweeps every first position from 0 to 63 in single mode and every pair of positions in dual mode. It checks where the range boundary falls at 38/39. A comparison off by one would flip a nonexistent bit and hand back an unchanged word with the flag low. It would also reject the top check bit. Equal positions in dual mode are checked, because a design that forgot them would cancel its own flip and report success on an intact word. Single mode is driven with junk in the second index, to catch a design that lets that index raise the flag or add a flip.

// File: rtl/cw_err_inject_pkg.sv
package cw_err_inject_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CHK_W  = 7;
  localparam int unsigned CW_W   = DATA_W + CHK_W;
  localparam int unsigned POS_W  = $clog2(CW_W);

  typedef logic [CW_W-1:0]  cw_t;
  typedef logic [POS_W-1:0] pos_t;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_DUAL   = 1'b1
  } inj_mode_e;
endpackage

// File: rtl/cw_pos_decode.sv
module cw_pos_decode #(
  parameter int unsigned WIDTH = 39,
  parameter int unsigned POS_W = $clog2(WIDTH)
) (
  input  logic [POS_W-1:0] pos_i,
  output logic             in_range_o,
  output logic [WIDTH-1:0] onehot_o
);
  localparam logic [POS_W-1:0] LIMIT = POS_W'(WIDTH);

  assign in_range_o = pos_i < LIMIT;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    assign onehot_o[g] = (pos_i == POS_W'(g));
  end
endmodule

// File: rtl/cw_req_check.sv
module cw_req_check #(
  parameter int unsigned POS_W = 6
) (
  input  logic [POS_W-1:0] pos_a_i,
  input  logic [POS_W-1:0] pos_b_i,
  input  logic             a_ok_i,
  input  logic             b_ok_i,
  input  logic             dual_i,
  output logic             en_a_o,
  output logic             en_b_o,
  output logic             bad_o
);
  logic same_pos;
  logic b_fault;

  assign same_pos = (pos_a_i == pos_b_i);
  // second index only matters in dual mode
  assign b_fault  = dual_i & (~b_ok_i | same_pos);
  assign bad_o    = ~a_ok_i | b_fault;
  assign en_a_o   = ~bad_o;
  assign en_b_o   = ~bad_o & dual_i;
endmodule

// File: rtl/cw_flip_apply.sv
module cw_flip_apply #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CHK_W  = 7,
  parameter int unsigned CW_W   = DATA_W + CHK_W
) (
  input  logic [CW_W-1:0]   cw_i,
  input  logic [CW_W-1:0]   mask_a_i,
  input  logic [CW_W-1:0]   mask_b_i,
  input  logic              en_a_i,
  input  logic              en_b_i,
  output logic [CW_W-1:0]   cw_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CHK_W-1:0]  chk_o
);
  logic [CW_W-1:0] flip;

  assign flip   = (mask_a_i & {CW_W{en_a_i}}) | (mask_b_i & {CW_W{en_b_i}});
  assign cw_o   = cw_i ^ flip;
  assign data_o = cw_o[DATA_W-1:0];
  assign chk_o  = cw_o[CW_W-1:DATA_W];
endmodule

// File: rtl/cw_err_inject.sv
module cw_err_inject
  import cw_err_inject_pkg::*;
(
  input  logic [CW_W-1:0]   cw_i,
  input  logic [POS_W-1:0]  pos_a_i,
  input  logic [POS_W-1:0]  pos_b_i,
  input  logic              mode_i,
  output logic [CW_W-1:0]   cw_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CHK_W-1:0]  chk_o,
  output logic              bad_req_o
);
  logic            a_ok, b_ok;
  logic [CW_W-1:0] mask_a, mask_b;
  logic            en_a, en_b;
  logic            dual;

  assign dual = (inj_mode_e'(mode_i) == MODE_DUAL);

  cw_pos_decode #(.WIDTH(CW_W), .POS_W(POS_W)) u_dec_a (
    .pos_i      (pos_a_i),
    .in_range_o (a_ok),
    .onehot_o   (mask_a)
  );

  cw_pos_decode #(.WIDTH(CW_W), .POS_W(POS_W)) u_dec_b (
    .pos_i      (pos_b_i),
    .in_range_o (b_ok),
    .onehot_o   (mask_b)
  );

  cw_req_check #(.POS_W(POS_W)) u_req (
    .pos_a_i (pos_a_i),
    .pos_b_i (pos_b_i),
    .a_ok_i  (a_ok),
    .b_ok_i  (b_ok),
    .dual_i  (dual),
    .en_a_o  (en_a),
    .en_b_o  (en_b),
    .bad_o   (bad_req_o)
  );

  cw_flip_apply #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW_W(CW_W)) u_flip (
    .cw_i     (cw_i),
    .mask_a_i (mask_a),
    .mask_b_i (mask_b),
    .en_a_i   (en_a),
    .en_b_i   (en_b),
    .cw_o     (cw_o),
    .data_o   (data_o),
    .chk_o    (chk_o)
  );
endmodule

// File: rtl/cw_err_inject_chk.sv
module cw_err_inject_chk
  import cw_err_inject_pkg::*;
(
  input logic [CW_W-1:0]   cw_i,
  input logic [POS_W-1:0]  pos_a_i,
  input logic [POS_W-1:0]  pos_b_i,
  input logic              mode_i,
  input logic [CW_W-1:0]   cw_o,
  input logic [DATA_W-1:0] data_o,
  input logic [CHK_W-1:0]  chk_o,
  input logic              bad_req_o
);
  localparam logic [POS_W-1:0] LIMIT = POS_W'(CW_W);

  logic [CW_W-1:0] diff;
  logic            known;

  assign diff  = cw_o ^ cw_i;
  assign known = !$isunknown({cw_i, pos_a_i, pos_b_i, mode_i, cw_o, data_o, chk_o, bad_req_o});

  always_comb begin
    if (known) begin
      AST_SINGLE_FLIP: assert (bad_req_o || mode_i || ($countones(diff) == 1 && diff[pos_a_i])); // R1
      AST_DUAL_FLIP: assert (bad_req_o || !mode_i ||
                             ($countones(diff) == 2 && diff[pos_a_i] && diff[pos_b_i])); // R2
      AST_A_RANGE: assert (pos_a_i < LIMIT || (bad_req_o && diff == '0)); // R4
      AST_B_RANGE: assert (!mode_i || pos_b_i < LIMIT || (bad_req_o && diff == '0)); // R5
      AST_SAME_POS: assert (!mode_i || pos_a_i != pos_b_i || (bad_req_o && diff == '0)); // R6
      AST_ERR_PRESENT: assert (bad_req_o || diff != '0); // R7
      AST_FIELDS: assert ({chk_o, data_o} == cw_o); // R8
    end
  end
endmodule

bind cw_err_inject cw_err_inject_chk u_chk (
  .cw_i      (cw_i),
  .pos_a_i   (pos_a_i),
  .pos_b_i   (pos_b_i),
  .mode_i    (mode_i),
  .cw_o      (cw_o),
  .data_o    (data_o),
  .chk_o     (chk_o),
  .bad_req_o (bad_req_o)
);

// File: tb/cw_err_inject_tb_top.sv
module cw_err_inject_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // {cw[38:0], pos_a[5:0], pos_b[5:0], mode, exp_bad}
  localparam logic [52:0] VEC [NVEC] = '{
    {39'h00_0000_0000, 6'd0,  6'd5,  1'b0, 1'b0},
    {39'h7F_FFFF_FFFF, 6'd38, 6'd63, 1'b0, 1'b0},
    {39'h12_3456_789A, 6'd39, 6'd1,  1'b0, 1'b1},
    {39'h55_AAAA_5555, 6'd31, 6'd32, 1'b1, 1'b0},
    {39'h2A_DEAD_BEEF, 6'd7,  6'd7,  1'b1, 1'b1},
    {39'h01_0000_0001, 6'd0,  6'd38, 1'b1, 1'b0},
    {39'h40_F0F0_0F0F, 6'd3,  6'd39, 1'b1, 1'b1},
    {39'h33_CCCC_3333, 6'd63, 6'd2,  1'b1, 1'b1}
  };

  logic        clk;
  logic        rst_ni;
  logic [38:0] cw_i;
  logic [5:0]  pos_a_i, pos_b_i;
  logic        mode_i;
  logic [38:0] cw_o;
  logic [31:0] data_o;
  logic [6:0]  chk_o;
  logic        bad_req_o;

  int checks = 0;
  int fails  = 0;

  cw_err_inject dut_i (
    .cw_i      (cw_i),
    .pos_a_i   (pos_a_i),
    .pos_b_i   (pos_b_i),
    .mode_i    (mode_i),
    .cw_o      (cw_o),
    .data_o    (data_o),
    .chk_o     (chk_o),
    .bad_req_o (bad_req_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic ref_bad(logic [5:0] a, logic [5:0] b, logic m);
    return (a > 6'd38) || (m && ((b > 6'd38) || (a == b)));
  endfunction

  function automatic logic [38:0] ref_out(logic [38:0] w, logic [5:0] a, logic [5:0] b, logic m);
    logic [38:0] r = w;
    if (!ref_bad(a, b, m)) begin
      for (int i = 0; i < 39; i++) begin
        if (i == int'(a) || (m && i == int'(b))) r[i] = ~r[i];
      end
    end
    return r;
  endfunction

  task automatic apply(logic [38:0] w, logic [5:0] a, logic [5:0] b, logic m);
    @(posedge clk);
    cw_i = w; pos_a_i = a; pos_b_i = b; mode_i = m;
    @(negedge clk);
  endtask

  task automatic check(string req, logic [38:0] exp_w, logic exp_b);
    checks++;
    if (cw_o !== exp_w || bad_req_o !== exp_b || {chk_o, data_o} !== exp_w) begin
      fails++;
      $display("FAIL %s: cw_o=%h bad=%b fields=%h expected cw=%h bad=%b",
               req, cw_o, bad_req_o, {chk_o, data_o}, exp_w, exp_b);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [38:0] w;
    logic [38:0] base;
    cw_i = '0; pos_a_i = '0; pos_b_i = '0; mode_i = 1'b0;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // reset-time state: zero word, position 0, single mode (R1, R9)
    @(negedge clk);
    check("R1 reset-state", 39'h1, 1'b0);

    // table walk (R1 R2 R4 R5 R6 R8)
    for (int v = 0; v < NVEC; v++) begin
      apply(VEC[v][52:14], VEC[v][13:8], VEC[v][7:2], VEC[v][1]);
      check("R8 table", ref_out(VEC[v][52:14], VEC[v][13:8], VEC[v][7:2], VEC[v][1]), VEC[v][0]);
      if (ref_bad(VEC[v][13:8], VEC[v][7:2], VEC[v][1]) !== VEC[v][0]) begin
        fails++;
        $display("FAIL table entry %0d: model bad=%b expected=%b", v,
                 ref_bad(VEC[v][13:8], VEC[v][7:2], VEC[v][1]), VEC[v][0]);
      end
    end

    // single mode, every first position including 38/39 boundary (R1 R4 R7)
    for (int a = 0; a < 64; a++) begin
      w = {$urandom, $urandom};
      apply(w, 6'(a), 6'(a), 1'b0);
      check(a < 39 ? "R1 single sweep" : "R4 a out of range",
            ref_out(w, 6'(a), 6'(a), 1'b0), a > 38);
    end

    // dual mode, every pair (R2 R4 R5 R6 R7)
    for (int a = 0; a < 64; a++) begin
      for (int b = 0; b < 64; b++) begin
        w = {$urandom, $urandom};
        apply(w, 6'(a), 6'(b), 1'b1);
        check(a == b ? "R6 equal pos" : (b > 38 ? "R5 b out of range" : "R2 dual sweep"),
              ref_out(w, 6'(a), 6'(b), 1'b1), ref_bad(6'(a), 6'(b), 1'b1));
      end
    end

    // single mode: second index ignored (R3)
    base = 39'h5A_0F0F_F0F0;
    for (int b = 0; b < 64; b++) begin
      apply(base, 6'd17, 6'(b), 1'b0);
      check("R3 pos_b ignored", base ^ (39'h1 << 17), 1'b0);
    end

    // top check bit and bottom data bit, field split (R8)
    apply('0, 6'd38, 6'd0, 1'b1);
    check("R8 field edges", {1'b1, 37'h0, 1'b1}, 1'b0);
    if (chk_o !== 7'h40 || data_o !== 32'h1) begin
      fails++;
      $display("FAIL R8: chk=%h data=%h expected chk=40 data=00000001", chk_o, data_o);
    end
    checks++;

    // same-cycle response without clock edge (R9)
    cw_i = 39'h7F_FFFF_FFFF; pos_a_i = 6'd32; pos_b_i = 6'd0; mode_i = 1'b0;
    #1;
    check("R9 combinational", 39'h7E_FFFF_FFFF, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule